// File: doc/BRIEF.md
# Rail Event Black-Box Recorder

This block keeps a rolling record of a supply rail's recent behaviour and freezes it when something goes wrong. Voltage, current and temperature samples arrive at a fixed sample rate, so each position in the buffer corresponds to a point in time. All three are written into one circular store. A rising edge on the event input, once enough history has built up, marks the trigger point. From then on the recorder collects a configurable number of further samples, freezes the store, and scans it to find the extremes. It then presents a header describing the event.

The header gives the event's type code and its cause bits, the timestamp taken from an external free-running tick, a sequence number that only power-on reset clears, and how long the event input stayed high. It also gives the lowest and highest voltage, the highest current and the highest temperature found anywhere in the captured window. The host reads the frozen samples through an offset port, oldest first, and releases the recorder with an acknowledge. Events that cannot be recorded are counted instead.

Top module: `evt_recorder`

## Requirements
- R1: Samples written while armed fill the ring. The captured window is the last PRE_N samples written before the accepting clock edge, followed by the next POST_N samples starting at that edge. Samples presented after the window is full are not stored until the host acknowledges.
- R2: An event is a rising edge of `trig_in`. It is accepted only while armed and only once PRE_N samples have been written since reset or since the last acknowledge. Any other rising edge, except one during post-capture, increments `drop_cnt` (saturating) and starts no record.
- R3: `hdr_valid` is low until the post-trigger samples are complete and the window has been scanned. It then stays high, with every header field unchanged, until a cycle with `hdr_ack` high, after which it drops.
- R4: `hdr_type` and `hdr_cause` are taken from `trig_type`/`trig_cause` at acceptance. Each further rising edge during post-capture ORs its cause bits into `hdr_cause` and neither starts a record nor counts as a drop. Cause bit 0 is undervoltage, bit 1 is power-good loss, bit 2 is mode change and bit 3 is hiccup.
- R5: `hdr_tick` equals `tick_in` as sampled at the accepting clock edge.
- R6: `hdr_seq` is 0 for the first record after reset and rises by one for each accepted record. Only `rst_n` clears it.
- R7: `hdr_dur` counts clock cycles with `trig_in` high. It starts at 1 on the accepting edge and stops at the first low cycle or at the end of post-capture, saturating at 2^DUR_W-1.
- R8: `hdr_vmin`/`hdr_vmax` are the lowest and highest voltage in the window. `hdr_imax` and `hdr_tmax` are the highest current and temperature in the window.
- R9: Presenting offset k on `rd_off` returns the k-th oldest window sample on `rd_v`/`rd_i`/`rd_t` one cycle later. Offset 0 is the oldest pre-trigger sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | Sample strobe at the fixed sample rate |
| samp_v | input | DW | Voltage sample |
| samp_i | input | DW | Current sample |
| samp_t | input | DW | Temperature sample |
| tick_in | input | TICK_W | Free-running monotonic tick |
| trig_in | input | 1 | Event level; rising edge fires |
| trig_type | input | TYPE_W | Event type code |
| trig_cause | input | 4 | Cause bits of the event |
| hdr_ack | input | 1 | Host releases the frozen record |
| rd_off | input | AW | Readout offset from the oldest sample |
| rd_v | output | DW | Read voltage |
| rd_i | output | DW | Read current |
| rd_t | output | DW | Read temperature |
| hdr_valid | output | 1 | Header and frozen buffer are ready |
| hdr_type | output | TYPE_W | Event type |
| hdr_cause | output | 4 | Accumulated cause bits |
| hdr_tick | output | TICK_W | Tick at acceptance |
| hdr_seq | output | SEQ_W | Record sequence number |
| hdr_dur | output | DUR_W | Event duration in cycles |
| hdr_vmin | output | DW | Window minimum voltage |
| hdr_vmax | output | DW | Window maximum voltage |
| hdr_imax | output | DW | Window maximum current |
| hdr_tmax | output | DW | Window maximum temperature |
| drop_cnt | output | DROP_W | Refused events, saturating |

## Verification
The bench builds the recorder with PRE_N=4, POST_N=6, DW=8 and DUR_W=6, so the whole ten-entry window can be read back at every offset. With a window this small, the ring wraps within a few records, and samples written while the record is frozen land on slots the readout would expose. The six-bit duration field saturates during a single held event. The short pre-fill makes refused triggers after reset and after acknowledge easy to reach, together with cause merging during post-capture and refusals while the record is held.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int CAUSE_W = 4;
  typedef enum logic [1:0] {ST_ARM, ST_POST, ST_SCAN, ST_HOLD} evr_state_e;
endpackage

// File: rtl/evr_ring.sv
module evr_ring #(
  parameter int DW    = 12,
  parameter int DEPTH = 1000,
  localparam int AW   = $clog2(DEPTH),
  localparam int WW   = 3 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_data,
  input  logic [AW-1:0] scan_addr,
  output logic [WW-1:0] scan_data,
  input  logic [AW-1:0] rd_off,
  output logic [WW-1:0] rd_data
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   DEP  = (AW + 1)'(DEPTH);

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rd_addr;
  logic [AW:0]   sum;

  always_comb begin
    wptr_d = wptr_q;
    if (wr_en) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    sum = {1'b0, wptr_q} + {1'b0, rd_off};
    if (sum >= DEP) sum = sum - DEP;
    rd_addr = sum[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  assign scan_data = mem[scan_addr];

  a_r1_wptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q <= LAST);
  a_r1_wptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wptr_q));
endmodule

// File: rtl/evr_extremes.sv
module evr_extremes #(
  parameter int DW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [3*DW-1:0] smp,
  output logic [DW-1:0]   vmin,
  output logic [DW-1:0]   vmax,
  output logic [DW-1:0]   imax,
  output logic [DW-1:0]   tmax
);
  logic [DW-1:0] vmin_d, vmax_d, imax_d, tmax_d, sv, si, st;

  assign {sv, si, st} = smp;

  always_comb begin
    vmin_d = vmin; vmax_d = vmax; imax_d = imax; tmax_d = tmax;
    if (clr) begin
      vmin_d = '1; vmax_d = '0; imax_d = '0; tmax_d = '0;
    end else if (en) begin
      if (sv < vmin) vmin_d = sv;
      if (sv > vmax) vmax_d = sv;
      if (si > imax) imax_d = si;
      if (st > tmax) tmax_d = st;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vmin <= '1; vmax <= '0; imax <= '0; tmax <= '0;
    end else begin
      vmin <= vmin_d; vmax <= vmax_d; imax <= imax_d; tmax <= tmax_d;
    end

  a_r8_max_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && $past(!clr) |-> vmax >= $past(vmax) && imax >= $past(imax));
endmodule

// File: rtl/evr_ctrl.sv
module evr_ctrl
  import evr_pkg::*;
#(
  parameter int PRE_N  = 200,
  parameter int POST_N = 800,
  parameter int TICK_W = 32,
  parameter int SEQ_W  = 16,
  parameter int DUR_W  = 16,
  parameter int TYPE_W = 4,
  parameter int DROP_W = 8,
  localparam int DEPTH = PRE_N + POST_N,
  localparam int AW    = $clog2(DEPTH),
  localparam int FW    = $clog2(PRE_N + 1),
  localparam int PW    = $clog2(POST_N + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_valid,
  input  logic               trig_in,
  input  logic [TYPE_W-1:0]  trig_type,
  input  logic [CAUSE_W-1:0] trig_cause,
  input  logic [TICK_W-1:0]  tick_in,
  input  logic               hdr_ack,
  output logic               wr_en,
  output logic [AW-1:0]      scan_addr,
  output logic               scan_en,
  output logic               scan_clr,
  output logic               hdr_valid,
  output logic [TYPE_W-1:0]  hdr_type,
  output logic [CAUSE_W-1:0] hdr_cause,
  output logic [TICK_W-1:0]  hdr_tick,
  output logic [SEQ_W-1:0]   hdr_seq,
  output logic [DUR_W-1:0]   hdr_dur,
  output logic [DROP_W-1:0]  drop_cnt
);
  localparam logic [FW-1:0]    FILL_FULL = FW'(PRE_N);
  localparam logic [PW-1:0]    POST_FULL = PW'(POST_N);
  localparam logic [AW-1:0]    SCAN_LAST = AW'(DEPTH - 1);
  localparam logic [DUR_W-1:0] DUR_MAX   = '1;
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  evr_state_e          state_q, state_d;
  logic [FW-1:0]       fill_q, fill_d;
  logic [PW-1:0]       post_q, post_d;
  logic [AW-1:0]       scan_q, scan_d;
  logic [DUR_W-1:0]    dur_q, dur_d;
  logic                drun_q, drun_d, trig_q;
  logic [TYPE_W-1:0]   type_q, type_d;
  logic [CAUSE_W-1:0]  cause_q, cause_d;
  logic [TICK_W-1:0]   tick_q, tick_d;
  logic [SEQ_W-1:0]    hseq_q, hseq_d, seq_q, seq_d;
  logic [DROP_W-1:0]   drop_q, drop_d;
  logic                rise, accept, drop_ev;

  assign rise    = trig_in & ~trig_q;
  assign accept  = (state_q == ST_ARM) && rise && (fill_q == FILL_FULL);
  assign drop_ev = rise && (((state_q == ST_ARM) && (fill_q != FILL_FULL))
                   || (state_q == ST_SCAN) || (state_q == ST_HOLD));
  assign wr_en   = samp_valid && ((state_q == ST_ARM)
                   || ((state_q == ST_POST) && (post_q != POST_FULL)));
  assign scan_en = (state_q == ST_SCAN);
  assign scan_clr = accept;
  assign scan_addr = scan_q;

  always_comb begin
    state_d = state_q; fill_d = fill_q; post_d = post_q; scan_d = scan_q;
    dur_d = dur_q; drun_d = drun_q; type_d = type_q; cause_d = cause_q;
    tick_d = tick_q; hseq_d = hseq_q; seq_d = seq_q; drop_d = drop_q;
    if (drop_ev && drop_q != DROP_MAX) drop_d = drop_q + 1'b1;
    unique case (state_q)
      ST_ARM: begin
        if (samp_valid && fill_q != FILL_FULL) fill_d = fill_q + 1'b1;
        if (accept) begin
          state_d = ST_POST;
          post_d  = samp_valid ? PW'(1) : '0;
          type_d  = trig_type;
          cause_d = trig_cause;
          tick_d  = tick_in;
          hseq_d  = seq_q;
          seq_d   = seq_q + 1'b1;
          dur_d   = DUR_W'(1);
          drun_d  = 1'b1;
        end
      end
      ST_POST: begin
        if (samp_valid && post_q != POST_FULL) post_d = post_q + 1'b1;
        if (rise) cause_d = cause_q | trig_cause;
        if (drun_q) begin
          if (!trig_in)              drun_d = 1'b0;
          else if (dur_q != DUR_MAX) dur_d  = dur_q + 1'b1;
        end
        if (post_q == POST_FULL) begin
          state_d = ST_SCAN;
          scan_d  = '0;
          drun_d  = 1'b0;
        end
      end
      ST_SCAN: begin
        if (scan_q == SCAN_LAST) state_d = ST_HOLD;
        else                     scan_d  = scan_q + 1'b1;
      end
      ST_HOLD: begin
        if (hdr_ack) begin
          state_d = ST_ARM;
          fill_d  = '0;
        end
      end
      default: state_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= ST_ARM; fill_q <= '0; post_q <= '0; scan_q <= '0;
      dur_q <= '0; drun_q <= 1'b0; trig_q <= 1'b0; type_q <= '0;
      cause_q <= '0; tick_q <= '0; hseq_q <= '0; seq_q <= '0; drop_q <= '0;
    end else begin
      state_q <= state_d; fill_q <= fill_d; post_q <= post_d; scan_q <= scan_d;
      dur_q <= dur_d; drun_q <= drun_d; trig_q <= trig_in; type_q <= type_d;
      cause_q <= cause_d; tick_q <= tick_d; hseq_q <= hseq_d; seq_q <= seq_d;
      drop_q <= drop_d;
    end

  assign hdr_valid = (state_q == ST_HOLD);
  assign hdr_type  = type_q;
  assign hdr_cause = cause_q;
  assign hdr_tick  = tick_q;
  assign hdr_seq   = hseq_q;
  assign hdr_dur   = dur_q;
  assign drop_cnt  = drop_q;

  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ack |=> hdr_valid);
  a_r3_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && $past(hdr_valid) |-> $stable(hdr_seq) && $stable(hdr_cause)
      && $stable(hdr_dur) && $stable(hdr_tick));
  a_r2_drop_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q != $past(drop_q) |-> $past(rise) && !$past(accept));
  a_r1_post_bound: assert property (@(posedge clk) disable iff (!rst_n)
    post_q <= POST_FULL && fill_q <= FILL_FULL);
  a_r6_seq_steps: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> seq_q == hseq_q + 1'b1);
endmodule

// File: rtl/evt_recorder.sv
module evt_recorder
  import evr_pkg::*;
#(
  parameter int DW     = 12,
  parameter int PRE_N  = 200,
  parameter int POST_N = 800,
  parameter int TICK_W = 32,
  parameter int SEQ_W  = 16,
  parameter int DUR_W  = 16,
  parameter int TYPE_W = 4,
  parameter int DROP_W = 8,
  localparam int DEPTH = PRE_N + POST_N,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_valid,
  input  logic [DW-1:0]      samp_v,
  input  logic [DW-1:0]      samp_i,
  input  logic [DW-1:0]      samp_t,
  input  logic [TICK_W-1:0]  tick_in,
  input  logic               trig_in,
  input  logic [TYPE_W-1:0]  trig_type,
  input  logic [CAUSE_W-1:0] trig_cause,
  input  logic               hdr_ack,
  input  logic [AW-1:0]      rd_off,
  output logic [DW-1:0]      rd_v,
  output logic [DW-1:0]      rd_i,
  output logic [DW-1:0]      rd_t,
  output logic               hdr_valid,
  output logic [TYPE_W-1:0]  hdr_type,
  output logic [CAUSE_W-1:0] hdr_cause,
  output logic [TICK_W-1:0]  hdr_tick,
  output logic [SEQ_W-1:0]   hdr_seq,
  output logic [DUR_W-1:0]   hdr_dur,
  output logic [DW-1:0]      hdr_vmin,
  output logic [DW-1:0]      hdr_vmax,
  output logic [DW-1:0]      hdr_imax,
  output logic [DW-1:0]      hdr_tmax,
  output logic [DROP_W-1:0]  drop_cnt
);
  logic          rst_s1, rst_sn;
  logic          wr_en, scan_en, scan_clr;
  logic [AW-1:0] scan_addr;
  logic [3*DW-1:0] scan_data, rd_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rst_sn, rst_s1} <= 2'b00;
    else        {rst_sn, rst_s1} <= {rst_s1, 1'b1};

  evr_ctrl #(
    .PRE_N(PRE_N), .POST_N(POST_N), .TICK_W(TICK_W), .SEQ_W(SEQ_W),
    .DUR_W(DUR_W), .TYPE_W(TYPE_W), .DROP_W(DROP_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_sn), .samp_valid(samp_valid), .trig_in(trig_in),
    .trig_type(trig_type), .trig_cause(trig_cause), .tick_in(tick_in),
    .hdr_ack(hdr_ack), .wr_en(wr_en), .scan_addr(scan_addr),
    .scan_en(scan_en), .scan_clr(scan_clr), .hdr_valid(hdr_valid),
    .hdr_type(hdr_type), .hdr_cause(hdr_cause), .hdr_tick(hdr_tick),
    .hdr_seq(hdr_seq), .hdr_dur(hdr_dur), .drop_cnt(drop_cnt)
  );

  evr_ring #(.DW(DW), .DEPTH(DEPTH)) ring_i (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en),
    .wr_data({samp_v, samp_i, samp_t}), .scan_addr(scan_addr),
    .scan_data(scan_data), .rd_off(rd_off), .rd_data(rd_data)
  );

  evr_extremes #(.DW(DW)) ext_i (
    .clk(clk), .rst_n(rst_sn), .clr(scan_clr), .en(scan_en),
    .smp(scan_data), .vmin(hdr_vmin), .vmax(hdr_vmax),
    .imax(hdr_imax), .tmax(hdr_tmax)
  );

  assign {rd_v, rd_i, rd_t} = rd_data;

  a_r8_min_le_max: assert property (@(posedge clk) disable iff (!rst_sn)
    hdr_valid |-> hdr_vmin <= hdr_vmax);
  a_r1_frozen_no_write: assert property (@(posedge clk) disable iff (!rst_sn)
    hdr_valid |-> !wr_en);
endmodule

// File: tb/evt_recorder_tb_top.sv
module evt_recorder_tb_top;
  localparam int DW = 8, PRE_N = 4, POST_N = 6, DEPTH = 10, AW = 4;
  localparam int TICK_W = 16, SEQ_W = 8, DUR_W = 6, TYPE_W = 3, DROP_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_valid = 1'b0;
  logic [DW-1:0] samp_v = '0, samp_i = '0, samp_t = '0;
  logic [TICK_W-1:0] tick = 16'hFFF0;
  logic trig_in = 1'b0;
  logic [TYPE_W-1:0] trig_type = '0;
  logic [3:0] trig_cause = '0;
  logic hdr_ack = 1'b0;
  logic [AW-1:0] rd_off = '0;
  logic [DW-1:0] rd_v, rd_i, rd_t, hdr_vmin, hdr_vmax, hdr_imax, hdr_tmax;
  logic hdr_valid;
  logic [TYPE_W-1:0] hdr_type;
  logic [3:0] hdr_cause;
  logic [TICK_W-1:0] hdr_tick;
  logic [SEQ_W-1:0] hdr_seq;
  logic [DUR_W-1:0] hdr_dur;
  logic [DROP_W-1:0] drop_cnt;

  int errors = 0, checks = 0, nsamp = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tick <= tick + 1'b1;

  evt_recorder #(.DW(DW), .PRE_N(PRE_N), .POST_N(POST_N), .TICK_W(TICK_W),
    .SEQ_W(SEQ_W), .DUR_W(DUR_W), .TYPE_W(TYPE_W), .DROP_W(DROP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_v(samp_v),
    .samp_i(samp_i), .samp_t(samp_t), .tick_in(tick), .trig_in(trig_in),
    .trig_type(trig_type), .trig_cause(trig_cause), .hdr_ack(hdr_ack),
    .rd_off(rd_off), .rd_v(rd_v), .rd_i(rd_i), .rd_t(rd_t),
    .hdr_valid(hdr_valid), .hdr_type(hdr_type), .hdr_cause(hdr_cause),
    .hdr_tick(hdr_tick), .hdr_seq(hdr_seq), .hdr_dur(hdr_dur),
    .hdr_vmin(hdr_vmin), .hdr_vmax(hdr_vmax), .hdr_imax(hdr_imax),
    .hdr_tmax(hdr_tmax), .drop_cnt(drop_cnt));

  function automatic int fv(int k); return 100 + (k * 7) % 40; endfunction
  function automatic int fi(int k); return 20 + (k * 13) % 50; endfunction
  function automatic int ft(int k); return 50 + (k * 5) % 30; endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n); repeat (n) @(negedge clk); endtask

  task automatic smp();
    samp_valid = 1'b1;
    samp_v = DW'(fv(nsamp)); samp_i = DW'(fi(nsamp)); samp_t = DW'(ft(nsamp));
    nsamp++;
    step(1);
    samp_valid = 1'b0;
  endtask

  task automatic pulse(logic [TYPE_W-1:0] ty, logic [3:0] c);
    trig_type = ty; trig_cause = c; trig_in = 1'b1;
    step(1);
    trig_in = 1'b0;
  endtask

  // first: index of oldest sample in the window
  task automatic check_window(int first);
    int vmn = 255, vmx = 0, imx = 0, tmx = 0;
    for (int k = 0; k < DEPTH; k++) begin
      if (fv(first + k) < vmn) vmn = fv(first + k);
      if (fv(first + k) > vmx) vmx = fv(first + k);
      if (fi(first + k) > imx) imx = fi(first + k);
      if (ft(first + k) > tmx) tmx = ft(first + k);
    end
    check("R8 vmin", hdr_vmin, vmn);
    check("R8 vmax", hdr_vmax, vmx);
    check("R8 imax", hdr_imax, imx);
    check("R8 tmax", hdr_tmax, tmx);
    for (int k = 0; k < DEPTH; k++) begin
      rd_off = AW'(k);
      step(1);
      check("R1/R9 readout v", rd_v, fv(first + k));
      check("R1/R9 readout i", rd_i, fi(first + k));
      check("R1/R9 readout t", rd_t, ft(first + k));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int exp_tick, first;
    step(3);
    rst_n = 1'b1;
    step(4);
    check("R3 reset hdr_valid", hdr_valid, 0);
    check("R2 reset drop_cnt", drop_cnt, 0);

    // Record 1
    smp(); smp();
    pulse(3'd1, 4'b0010);                // too little history
    step(2);
    check("R2 early trigger dropped", drop_cnt, 1);
    check("R2 early trigger no record", hdr_valid, 0);
    repeat (5) begin smp(); step(1); end // nsamp = 7
    first = nsamp - PRE_N;
    trig_type = 3'd3; trig_cause = 4'b0001; trig_in = 1'b1;
    exp_tick = tick;
    step(5);
    trig_in = 1'b0;
    smp(); smp(); smp();
    pulse(3'd5, 4'b0100);                // merge during post-capture
    smp(); smp(); smp();                 // 6 post samples written
    check("R3 not valid before scan", hdr_valid, 0);
    check("R4 merge not dropped", drop_cnt, 1);
    step(DEPTH + 5);
    check("R3 header valid", hdr_valid, 1);
    check("R4 type", hdr_type, 3);
    check("R4 cause merged", hdr_cause, 4'b0101);
    check("R5 tick", hdr_tick, exp_tick);
    check("R6 first seq", hdr_seq, 0);
    check("R7 duration", hdr_dur, 5);
    smp(); smp();                        // ignored while frozen
    pulse(3'd2, 4'b1000);                // refused while held
    step(2);
    check("R2 drop while held", drop_cnt, 2);
    check("R3 still valid", hdr_valid, 1);
    check("R3 cause unchanged", hdr_cause, 4'b0101);
    check_window(first);

    hdr_ack = 1'b1; step(1); hdr_ack = 1'b0;
    step(1);
    check("R3 released by ack", hdr_valid, 0);

    // Record 2
    smp();
    pulse(3'd1, 4'b0001);                // history restarts after ack
    step(2);
    check("R2 drop after ack", drop_cnt, 3);
    smp(); smp(); smp();
    first = nsamp - PRE_N;
    trig_type = 3'd2; trig_cause = 4'b1010; trig_in = 1'b1;
    exp_tick = tick;
    repeat (POST_N) begin smp(); step(14); end
    step(DEPTH + 5);
    check("R3 second header valid", hdr_valid, 1);
    check("R6 second seq", hdr_seq, 1);
    check("R7 duration saturates", hdr_dur, 63);
    check("R4 second cause", hdr_cause, 4'b1010);
    check("R4 second type", hdr_type, 2);
    check("R5 second tick", hdr_tick, exp_tick);
    trig_in = 1'b0;
    step(2);
    check("R2 falling edge not dropped", drop_cnt, 3);
    check_window(first);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule